// File: doc/BRIEF.md
# Half-Duplex Converter Interface Controller

This block is the host-side controller for a time-division-duplex data converter. The converter holds a 7-bit transmit DAC and a 5-bit receive ADC, and the two share one parallel data bus. The controller turns a requested mode into the converter's two enable lines. After every exit from shutdown it holds off traffic for a programmable number of clock cycles. In transmit it sends samples with edge timing the converter can latch. In receive it captures samples and hands them on. It also controls the direction of the shared lines.

The converter runs on the same clock as the controller. In transmit the converter latches bus data on the falling edge, so the controller changes data only on the rising edge. In receive the converter changes its outputs on the rising edge, so the controller samples them on the falling edge and retimes them onto the rising-edge domain. The bus reaches the pad ring as separate output, output-enable and input signals. Transmit samples arrive on a valid/ready stream. Receive samples leave on a valid-only stream with no backpressure.

Top module: `tdd_conv_ctrl`

## Requirements
- R1: `conv_tx_en_o`=1 with `conv_rx_en_o`=0 means transmit, `conv_rx_en_o`=1 with `conv_tx_en_o`=0 means receive, and both low means shutdown. The two enables are never high together.
- R2: `mode_req_i` decodes as follows: 2'b01 requests transmit, 2'b10 requests receive, and 2'b00 and 2'b11 both request shutdown (both enables low).
- R3: When an enable rises out of shutdown, `tx_ready_o` goes high after exactly WAKE_CYC clock cycles with the transmit enable high. The first `rx_valid_o` comes WAKE_CYC+1 cycles after the receive enable rises.
- R4: A change of request while waking or active drops both enables for at least one cycle before the other enable rises, and the full wake wait then runs again.
- R5: `tx_ready_o` is high only in transmit mode once the wake wait has ended.
- R6: A 7-bit twos-complement sample (bit 6 is the MSB) accepted with `tx_valid_i`&`tx_ready_o` at a rising edge appears on `conv_dat_o` right after that edge. It stays unchanged until the next rising edge, so it is stable across the falling edge between them.
- R7: In transmit mode, any cycle that follows a rising edge with no accepted sample drives the zero code 7'b0000000 (mid-scale). This includes the whole wake wait and any underflow.
- R8: `conv_dat_oe_o` is high exactly while the transmit enable is high. Whenever it is low, `conv_dat_o` is all zeros, so the shared low lines are never driven high in shutdown or receive.
- R9: A 5-bit twos-complement receive sample (bit 4 is the MSB) placed on `conv_dat_i` after rising edge k is captured at the falling edge of that cycle. It appears on `rx_data_o`, with `rx_valid_o` high, after rising edge k+1.
- R10: `rx_valid_o` pulses once per converter sample, for every cycle of receive mode after the wake wait, and never outside it.
- R11: While `rst_ni` is low, both enables, `conv_dat_oe_o`, `tx_ready_o` and `rx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, also the converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Requested mode: 01 transmit, 10 receive, 00/11 shutdown |
| tx_valid_i | input | 1 | Transmit sample valid |
| tx_data_i | input | TX_W | Transmit sample, twos complement |
| tx_ready_o | output | 1 | Transmit sample accepted this cycle |
| rx_valid_o | output | 1 | Receive sample valid (one-cycle pulse) |
| rx_data_o | output | RX_W | Receive sample, twos complement |
| conv_tx_en_o | output | 1 | Converter transmit enable |
| conv_rx_en_o | output | 1 | Converter receive enable |
| conv_dat_o | output | TX_W | Shared bus, output value |
| conv_dat_oe_o | output | 1 | Shared bus, output enable |
| conv_dat_i | input | RX_W | Shared bus low lines, input value |

## Verification
The bench builds the block with WAKE_CYC=6 and the default 7-bit transmit and 5-bit receive widths. This keeps each wake wait short, so one run can cover several shutdown exits and both direct mode swaps. The wait is still long enough that an off-by-one in the countdown moves the first ready or valid by a visible cycle. The default widths bring the full-scale codes 0111111 and 1000000 and the receive extremes 01111 and 10000 onto the bus.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

  typedef enum logic [1:0] {
    MD_NONE = 2'b00,
    MD_TX   = 2'b01,
    MD_RX   = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_OFF,
    SEQ_WAKE,
    SEQ_LIVE
  } seq_st_e;

  function automatic mode_e decode_req(input logic [1:0] req);
    case (req)
      2'b01:   return MD_TX;
      2'b10:   return MD_RX;
      default: return MD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tdd_mode_seq.sv
module tdd_mode_seq
  import tdd_pkg::*;
#(
  parameter int WAKE_CYC = 36
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_req_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       tx_live_o,
  output logic       rx_live_o
);

  localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam int AGE_W = $clog2(WAKE_CYC + 1) + 1;

  seq_st_e          state_q;
  mode_e            cur_q;
  logic [CNT_W-1:0] cnt_q;
  mode_e            req_mode;

  assign req_mode = decode_req(mode_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_OFF;
      cur_q   <= MD_NONE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_OFF: begin
          if (req_mode != MD_NONE) begin
            cur_q   <= req_mode;
            cnt_q   <= CNT_W'(WAKE_CYC - 1);
            state_q <= SEQ_WAKE;
          end
        end
        SEQ_WAKE: begin
          if (req_mode != cur_q) begin
            cur_q   <= MD_NONE;
            state_q <= SEQ_OFF;
          end else if (cnt_q == '0) begin
            state_q <= SEQ_LIVE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_LIVE: begin
          // any change forces a pass through shutdown (R4)
          if (req_mode != cur_q) begin
            cur_q   <= MD_NONE;
            state_q <= SEQ_OFF;
          end
        end
        default: begin
          cur_q   <= MD_NONE;
          state_q <= SEQ_OFF;
        end
      endcase
    end
  end

  assign tx_en_o   = (cur_q == MD_TX);
  assign rx_en_o   = (cur_q == MD_RX);
  assign tx_live_o = (state_q == SEQ_LIVE) && (cur_q == MD_TX);
  assign rx_live_o = (state_q == SEQ_LIVE) && (cur_q == MD_RX);

  // independent age counter for the wake-window check
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (!(tx_en_o || rx_en_o)) age_q <= '0;
    else if (age_q != AGE_W'(WAKE_CYC)) age_q <= age_q + 1'b1;
  end

  assert_en_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_o && rx_en_o));

  assert_wake_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_live_o || rx_live_o) |-> (age_q == AGE_W'(WAKE_CYC)));

  assert_gap_to_rx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> !$past(tx_en_o));

  assert_gap_to_tx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> !$past(rx_en_o));

endmodule

// File: rtl/tdd_tx_path.sv
module tdd_tx_path #(
  parameter int TX_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_en_i,
  input  logic            tx_live_i,
  input  logic            tx_valid_i,
  input  logic [TX_W-1:0] tx_data_i,
  output logic            tx_ready_o,
  output logic [TX_W-1:0] dat_o,
  output logic            oe_o
);

  logic [TX_W-1:0] dat_q;

  assign tx_ready_o = tx_live_i;

  // rising-edge update keeps data settled around the converter's falling-edge latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dat_q <= '0;
    else if (tx_live_i && tx_valid_i) dat_q <= tx_data_i;
    else                              dat_q <= '0;
  end

  assign oe_o  = tx_en_i;
  assign dat_o = tx_en_i ? dat_q : '0;

  assert_ready_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_en_i);

  assert_sample_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && tx_valid_i) |=> (!tx_en_i || (dat_o == $past(tx_data_i))));

  assert_underflow_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !(tx_ready_o && tx_valid_i)) |=> (!tx_en_i || (dat_o == '0)));

endmodule

// File: rtl/tdd_rx_path.sv
module tdd_rx_path #(
  parameter int RX_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_live_i,
  input  logic [RX_W-1:0] dat_i,
  output logic            rx_valid_o,
  output logic [RX_W-1:0] rx_data_o
);

  logic [RX_W-1:0] cap_q;
  logic            valid_q;
  logic [RX_W-1:0] data_q;

  // converter moves its outputs on the rising edge; sample mid-cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else         cap_q <= dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rx_live_i;
      data_q  <= rx_live_i ? cap_q : '0;
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_data_o  = data_q;

  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_data_o == $past(cap_q)));

endmodule

// File: rtl/tdd_conv_ctrl.sv
module tdd_conv_ctrl #(
  parameter int TX_W     = 7,
  parameter int RX_W     = 5,
  parameter int WAKE_CYC = 36
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_req_i,
  input  logic            tx_valid_i,
  input  logic [TX_W-1:0] tx_data_i,
  output logic            tx_ready_o,
  output logic            rx_valid_o,
  output logic [RX_W-1:0] rx_data_o,
  output logic            conv_tx_en_o,
  output logic            conv_rx_en_o,
  output logic [TX_W-1:0] conv_dat_o,
  output logic            conv_dat_oe_o,
  input  logic [RX_W-1:0] conv_dat_i
);

  logic tx_en, rx_en, tx_live, rx_live;

  tdd_mode_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_req_i (mode_req_i),
    .tx_en_o    (tx_en),
    .rx_en_o    (rx_en),
    .tx_live_o  (tx_live),
    .rx_live_o  (rx_live)
  );

  tdd_tx_path #(.TX_W(TX_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en),
    .tx_live_i  (tx_live),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_ready_o (tx_ready_o),
    .dat_o      (conv_dat_o),
    .oe_o       (conv_dat_oe_o)
  );

  tdd_rx_path #(.RX_W(RX_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_live_i  (rx_live),
    .dat_i      (conv_dat_i),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o)
  );

  assign conv_tx_en_o = tx_en;
  assign conv_rx_en_o = rx_en;

  assert_bus_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_tx_en_o |-> (!conv_dat_oe_o && (conv_dat_o == '0)));

  assert_valid_in_rx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(conv_rx_en_o));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R11: assert (!conv_tx_en_o && !conv_rx_en_o && !conv_dat_oe_o);
    end
  end

endmodule

// File: tb/tdd_conv_ctrl_tb_top.sv
module tdd_conv_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE       = 6;
  localparam int TXW        = 7;
  localparam int RXW        = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     mode_req = 2'b00;
  logic           tx_valid = 1'b0;
  logic [TXW-1:0] tx_data = '0;
  logic           tx_ready;
  logic           rx_valid;
  logic [RXW-1:0] rx_data;
  logic           tx_en, rx_en;
  logic [TXW-1:0] dat_o;
  logic           dat_oe;
  logic [RXW-1:0] dat_i = '0;

  int total = 0;
  int bad   = 0;
  int rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdd_conv_ctrl #(.TX_W(TXW), .RX_W(RXW), .WAKE_CYC(WAKE)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mode_req_i    (mode_req),
    .tx_valid_i    (tx_valid),
    .tx_data_i     (tx_data),
    .tx_ready_o    (tx_ready),
    .rx_valid_o    (rx_valid),
    .rx_data_o     (rx_data),
    .conv_tx_en_o  (tx_en),
    .conv_rx_en_o  (rx_en),
    .conv_dat_o    (dat_o),
    .conv_dat_oe_o (dat_oe),
    .conv_dat_i    (dat_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model, receive side: new sample just after each rising edge
  initial begin
    int  age = 0;
    bit  prx = 1'b0;
    logic [RXW-1:0] s = 5'h0b;
    forever begin
      @(posedge clk);
      #1;
      if (rx_en && !tx_en) begin
        age = prx ? age + 1 : 0;
        s   = RXW'(s * 5 + 3);
        dat_i = s;
        if (age >= WAKE) rxq.push_back(int'(s));
      end else begin
        dat_i = '0;
      end
      prx = rx_en && !tx_en;
    end
  end

  // monitor / scoreboard, sampled at the falling edge
  initial begin
    bit ptx = 0, prx = 0, prdy = 0, pend = 0, rgot = 0;
    int pexp = 0, twc = 0, rwc = 0, e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(!(tx_en && rx_en), "R1 enables exclusive", {tx_en, rx_en}, 0);
        if ((tx_en && prx) || (rx_en && ptx))
          chk(1'b0, "R4 no direct swap", {tx_en, rx_en, ptx, prx}, 0);
        if (!tx_en) chk(!dat_oe && dat_o == '0, "R8 bus released", {dat_oe, dat_o}, 0);
        else        chk(dat_oe, "R8 oe in transmit", dat_oe, 1);
        if (tx_en) begin
          if (pend) chk(dat_o == TXW'(pexp), "R6 tx sample", dat_o, pexp);
          else      chk(dat_o == '0, "R7 zero code", dat_o, 0);
        end
        if (tx_ready) chk(tx_en, "R5 ready only in tx", tx_en, 1);
        if (tx_en && !ptx) twc = 0;
        if (tx_en && !tx_ready) twc++;
        if (tx_ready && !prdy) chk(twc == WAKE, "R3 tx wake", twc, WAKE);
        if (rx_en && !prx) begin rwc = 0; rgot = 0; end
        if (rx_en && !rx_valid && !rgot) rwc++;
        if (rx_valid && !rgot) begin
          rgot = 1;
          chk(rwc == WAKE + 1, "R3 rx wake", rwc, WAKE + 1);
        end
        if (rx_valid) begin
          if (rxq.size() == 0) chk(1'b0, "R10 unexpected valid", rx_data, -1);
          else begin
            e = rxq.pop_front();
            chk(rx_data == RXW'(e), "R9 rx sample", rx_data, e);
          end
        end
        ptx = tx_en; prx = rx_en; prdy = tx_ready;
      end
      #2;
      pend = tx_valid && tx_ready;
      pexp = int'(tx_data);
    end
  end

  task automatic tx_send(input logic [TXW-1:0] v);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    #1 tx_valid = 1'b1; tx_data = v;
    @(negedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic tx_burst(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      #1 tx_valid = 1'b1; tx_data = TXW'(seed + i * 37);
    end
    @(negedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    #1 mode_req = m;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog R3: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    #2;
    chk(!tx_en && !rx_en && !dat_oe && !tx_ready && !rx_valid, "R11 reset state",
        {tx_en, rx_en, dat_oe, tx_ready, rx_valid}, 0);
    @(negedge clk); #1 rst_n = 1'b1;

    // transmit: full-scale corners, underflow gaps, back-to-back burst
    set_mode(2'b01);
    idle(2);
    chk(tx_en && !rx_en, "R1 R2 transmit decode", {tx_en, rx_en}, 2);
    tx_send(7'h3f);
    tx_send(7'h40);
    tx_send(7'h00);
    idle(2);
    tx_send(7'h7f);
    tx_burst(8, 5);
    idle(3);

    // both-high request means shutdown
    set_mode(2'b11);
    idle(3);
    chk(!tx_en && !rx_en, "R2 req 11 shutdown", {tx_en, rx_en}, 0);

    // receive
    set_mode(2'b10);
    idle(3);
    chk(rx_en && !tx_en, "R1 R2 receive decode", {tx_en, rx_en}, 1);
    idle(25);

    // direct receive -> transmit swap
    set_mode(2'b01);
    tx_burst(4, 100);
    tx_send(7'h41);
    // direct transmit -> receive swap
    set_mode(2'b10);
    idle(20);

    set_mode(2'b00);
    idle(5);
    chk(!tx_en && !rx_en, "R2 req 00 shutdown", {tx_en, rx_en}, 0);
    chk(rxq.size() == 0, "R10 all rx samples delivered", rxq.size(), 0);
    chk(!rx_valid && !tx_ready, "R10 quiet in shutdown", {rx_valid, tx_ready}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule